// File: doc/BRIEF.md
# Branch-Folding Instruction Queue

This block is an eight-slot, in-order holding queue between instruction fetch and dispatch. Fetch writes a group of instruction words, each tagged with its address. Every cycle the block offers up to three of its oldest instructions to the execution core. Branches never reach the core: a scanner looks at the oldest four slots, finds the oldest branch and decides whether it can be settled now. An unconditional jump, or a conditional branch whose condition-register bit is already valid, is removed from the queue inside the block.

When such a branch goes the other way from straight-line code, everything younger than it is discarded, and a redirect carrying the target address is raised to fetch in the same cycle. A resolved conditional that falls through is simply deleted, and the instructions behind it close the gap. A conditional branch whose condition bit is not yet valid waits at its slot. While it waits, it holds back itself and everything behind it.

Instruction encoding used by the block: bits [31:26] give the opcode. Opcode 0x12 is an unconditional jump with a signed word displacement in [25:2]. Opcode 0x10 is a conditional branch with the sense bit in [25], the condition-register bit index in [20:16] and a signed word displacement in [15:2]. It is taken when the selected condition bit equals the sense bit. The target of either branch is its own address plus the displacement shifted left by two. Every other opcode is an ordinary instruction.

Top module: `brfold_iq`

## Requirements
- R1: After reset the queue is empty: no dispatch lane is valid, no redirect is raised and `fetch_free` reads 8.
- R2: A fetch cycle writes min(`fetch_cnt`, `fetch_free`) words. Lane i of the group is stored with address `fetch_pc` + 4·i. Words beyond the free space are dropped.
- R3: Up to three instructions are offered per cycle, oldest on lane 0, in program order. The valid lanes form a contiguous run from lane 0. Offered instructions leave the queue at the next clock edge.
- R4: A branch is never offered on a dispatch lane. A conditional branch whose condition bit is not valid stays queued and blocks itself and all younger entries.
- R5: An unconditional jump among the four oldest entries is removed. All younger entries are flushed, and `redirect_valid` is raised in that cycle with its target. Older entries are still dispatched.
- R6: A conditional branch with a valid condition bit equal to its sense bit is handled like R5, with its target address.
- R7: A conditional branch with a valid condition bit differing from its sense bit is removed without redirect. Younger entries are kept in order.
- R8: Only the four oldest entries are scanned. A branch in a younger slot is acted on only after it moves into that window.
- R9: At most one branch is removed per cycle, and it is the oldest branch in the window.
- R10: A fetch group that arrives in a cycle with a redirect is discarded.
- R11: `fetch_free` equals eight minus the number of stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch group is presented |
| fetch_cnt | input | 4 | Number of words in the group |
| fetch_pc | input | 32 | Address of group lane 0 |
| fetch_words | input | 256 | Group words, lane i at bits [32i+31:32i] |
| fetch_free | output | 4 | Free slots this cycle |
| cr_value | input | 32 | Condition-register bits |
| cr_valid | input | 32 | Per-bit valid flags of the condition register |
| disp_valid | output | 3 | Valid flags of the dispatch lanes |
| disp_words | output | 96 | Dispatched words, lane i at [32i+31:32i] |
| disp_pc | output | 96 | Addresses of the dispatched words |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Target of the removed taken branch |

## Verification
A taken jump can be removed in the same cycle that older instructions go to dispatch and that fetch presents a new group. The bench loads two plain instructions, a jump and one trailing instruction in a single group, then presents a fresh fetch group while the redirect is showing. It expects the two older instructions on lanes 0 and 1 and the redirect target in that same cycle. One cycle later it expects an empty queue, which shows that the trailing entry was flushed and the colliding fetch group was dropped.

// File: rtl/brfold_pkg.sv
package brfold_pkg;

    localparam logic [5:0] OPC_JUMP  = 6'h12;
    localparam logic [5:0] OPC_BCOND = 6'h10;

    typedef enum logic [1:0] {
        BK_NONE,
        BK_UNCOND,
        BK_COND
    } br_kind_e;

    typedef struct packed {
        logic        vld;
        logic [31:0] word;
        logic [31:0] pc;
    } iq_entry_t;

    function automatic br_kind_e classify(input logic [31:0] w);
        if (w[31:26] == OPC_JUMP)  return BK_UNCOND;
        if (w[31:26] == OPC_BCOND) return BK_COND;
        return BK_NONE;
    endfunction

    function automatic logic [4:0] cond_bit(input logic [31:0] w);
        return w[20:16];
    endfunction

    function automatic logic cond_sense(input logic [31:0] w);
        return w[25];
    endfunction

    function automatic logic [31:0] branch_target(input logic [31:0] w,
                                                  input logic [31:0] pc);
        case (classify(w))
            BK_UNCOND: return pc + {{6{w[25]}}, w[25:2], 2'b00};
            BK_COND:   return pc + {{16{w[15]}}, w[15:2], 2'b00};
            default:   return pc + 32'd4;
        endcase
    endfunction

endpackage

// File: rtl/brfold_scan.sv
module brfold_scan
    import brfold_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SCAN_W = 4,
    localparam int IDXW  = $clog2(DEPTH)
) (
    input  iq_entry_t         ent [DEPTH],
    input  logic [31:0]       cr_value,
    input  logic [31:0]       cr_valid,
    output logic              fold_hit,
    output logic              fold_taken,
    output logic [IDXW-1:0]   fold_idx,
    output logic [31:0]       fold_target
);

    // Oldest branch in the window decides; a pending one stops the search.
    always_comb begin
        logic     found;
        br_kind_e kind;
        found       = 1'b0;
        fold_hit    = 1'b0;
        fold_taken  = 1'b0;
        fold_idx    = '0;
        fold_target = '0;
        for (int i = 0; i < SCAN_W; i++) begin
            kind = classify(ent[i].word);
            if (!found && ent[i].vld && kind != BK_NONE) begin
                found       = 1'b1;
                fold_idx    = IDXW'(i);
                fold_target = branch_target(ent[i].word, ent[i].pc);
                if (kind == BK_UNCOND) begin
                    fold_hit   = 1'b1;
                    fold_taken = 1'b1;
                end else if (cr_valid[cond_bit(ent[i].word)]) begin
                    fold_hit   = 1'b1;
                    fold_taken = (cr_value[cond_bit(ent[i].word)] == cond_sense(ent[i].word));
                end
            end
        end
    end

endmodule

// File: rtl/brfold_disp.sv
module brfold_disp
    import brfold_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DISP_W = 3,
    localparam int DCW   = $clog2(DISP_W+1)
) (
    input  logic              clk,
    input  logic              rst,
    input  iq_entry_t         ent [DEPTH],
    output logic [DCW-1:0]    disp_cnt,
    output logic [DISP_W-1:0] disp_valid,
    output logic [DISP_W*32-1:0] disp_words,
    output logic [DISP_W*32-1:0] disp_pc
);

    always_comb begin
        logic stop;
        stop       = 1'b0;
        disp_cnt   = '0;
        disp_valid = '0;
        disp_words = '0;
        disp_pc    = '0;
        for (int i = 0; i < DISP_W; i++) begin
            if (!stop && ent[i].vld && classify(ent[i].word) == BK_NONE) begin
                disp_valid[i]       = 1'b1;
                disp_cnt            = disp_cnt + DCW'(1);
                disp_words[i*32 +: 32] = ent[i].word;
                disp_pc[i*32 +: 32]    = ent[i].pc;
            end else begin
                stop = 1'b1;
            end
        end
    end

    // R3: valid lanes are a contiguous run starting at lane 0
    p_lanes_packed_r3: assert property (@(posedge clk) disable iff (rst)
        ((disp_valid >> 1) & ~disp_valid) == '0);

endmodule

// File: rtl/brfold_store.sv
module brfold_store
    import brfold_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int FETCH_W = 8,
    parameter int DISP_W  = 3,
    localparam int IDXW   = $clog2(DEPTH),
    localparam int CNTW   = $clog2(DEPTH+1),
    localparam int FCW    = $clog2(FETCH_W+1),
    localparam int DCW    = $clog2(DISP_W+1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DCW-1:0]       disp_cnt,
    input  logic                 fold_hit,
    input  logic                 fold_taken,
    input  logic [IDXW-1:0]      fold_idx,
    input  logic                 fetch_valid,
    input  logic [FCW-1:0]       fetch_cnt,
    input  logic [31:0]          fetch_pc,
    input  logic [FETCH_W*32-1:0] fetch_words,
    output iq_entry_t            ent [DEPTH],
    output logic [CNTW-1:0]      free_cnt
);

    iq_entry_t       q   [DEPTH];
    iq_entry_t       nxt [DEPTH];
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] cnt_nxt;
    logic [DEPTH-1:0] vld_vec;

    assign free_cnt = CNTW'(DEPTH) - cnt_q;

    always_comb begin
        int  wp;
        int  acc;
        logic keep;
        wp = 0;
        for (int i = 0; i < DEPTH; i++) nxt[i] = '0;
        // survivors: not dispatched, not the folded branch, not behind a taken fold
        for (int i = 0; i < DEPTH; i++) begin
            keep = q[i].vld && (i >= int'(disp_cnt));
            if (fold_hit && i == int'(fold_idx)) keep = 1'b0;
            if (fold_hit && fold_taken && i > int'(fold_idx)) keep = 1'b0;
            if (keep && wp < DEPTH) begin
                nxt[wp] = q[i];
                wp      = wp + 1;
            end
        end
        // a redirect discards the incoming group
        acc = 0;
        if (fetch_valid && !(fold_hit && fold_taken))
            acc = (int'(fetch_cnt) < int'(free_cnt)) ? int'(fetch_cnt) : int'(free_cnt);
        for (int f = 0; f < FETCH_W; f++) begin
            if (f < acc && wp < DEPTH) begin
                nxt[wp].vld  = 1'b1;
                nxt[wp].word = fetch_words[f*32 +: 32];
                nxt[wp].pc   = fetch_pc + 32'(4 * f);
                wp           = wp + 1;
            end
        end
        cnt_nxt = CNTW'(wp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
            cnt_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) q[i] <= nxt[i];
            cnt_q <= cnt_nxt;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_out
            assign ent[g]     = q[g];
            assign vld_vec[g] = q[g].vld;
        end
    endgenerate

    // R11: occupancy count agrees with the stored valid flags
    p_occupancy_r11: assert property (@(posedge clk) disable iff (rst)
        $countones(vld_vec) == int'(cnt_q));

    // R2: the queue never holds more than its depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH);

    // R10: a taken fold never lets the stored count grow
    p_redirect_drops_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        (fold_hit && fold_taken) |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/brfold_iq.sv
module brfold_iq
    import brfold_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int FETCH_W = 8,
    parameter int DISP_W  = 3,
    parameter int SCAN_W  = 4,
    localparam int CNTW   = $clog2(DEPTH+1),
    localparam int FCW    = $clog2(FETCH_W+1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fetch_valid,
    input  logic [FCW-1:0]        fetch_cnt,
    input  logic [31:0]           fetch_pc,
    input  logic [FETCH_W*32-1:0] fetch_words,
    output logic [CNTW-1:0]       fetch_free,
    input  logic [31:0]           cr_value,
    input  logic [31:0]           cr_valid,
    output logic [DISP_W-1:0]     disp_valid,
    output logic [DISP_W*32-1:0]  disp_words,
    output logic [DISP_W*32-1:0]  disp_pc,
    output logic                  redirect_valid,
    output logic [31:0]           redirect_pc
);

    localparam int IDXW = $clog2(DEPTH);
    localparam int DCW  = $clog2(DISP_W+1);

    iq_entry_t        ent [DEPTH];
    logic             fold_hit;
    logic             fold_taken;
    logic [IDXW-1:0]  fold_idx;
    logic [31:0]      fold_target;
    logic [DCW-1:0]   disp_cnt;

    brfold_scan #(.DEPTH(DEPTH), .SCAN_W(SCAN_W)) u_scan (
        .ent         (ent),
        .cr_value    (cr_value),
        .cr_valid    (cr_valid),
        .fold_hit    (fold_hit),
        .fold_taken  (fold_taken),
        .fold_idx    (fold_idx),
        .fold_target (fold_target)
    );

    brfold_disp #(.DEPTH(DEPTH), .DISP_W(DISP_W)) u_disp (
        .clk        (clk),
        .rst        (rst),
        .ent        (ent),
        .disp_cnt   (disp_cnt),
        .disp_valid (disp_valid),
        .disp_words (disp_words),
        .disp_pc    (disp_pc)
    );

    brfold_store #(.DEPTH(DEPTH), .FETCH_W(FETCH_W), .DISP_W(DISP_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .disp_cnt    (disp_cnt),
        .fold_hit    (fold_hit),
        .fold_taken  (fold_taken),
        .fold_idx    (fold_idx),
        .fetch_valid (fetch_valid),
        .fetch_cnt   (fetch_cnt),
        .fetch_pc    (fetch_pc),
        .fetch_words (fetch_words),
        .ent         (ent),
        .free_cnt    (fetch_free)
    );

    assign redirect_valid = fold_hit && fold_taken;
    assign redirect_pc    = fold_target;

    // R5: after a redirect only older, non-branch work can remain
    p_redirect_single_r5: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid);

endmodule

// File: tb/brfold_iq_bench.sv
`timescale 1ns/1ps
module brfold_iq_bench;

    logic          clk = 1'b0;
    logic          rst;
    logic          fetch_valid;
    logic [3:0]    fetch_cnt;
    logic [31:0]   fetch_pc;
    logic [255:0]  fetch_words;
    logic [3:0]    fetch_free;
    logic [31:0]   cr_value;
    logic [31:0]   cr_valid;
    logic [2:0]    disp_valid;
    logic [95:0]   disp_words;
    logic [95:0]   disp_pc;
    logic          redirect_valid;
    logic [31:0]   redirect_pc;

    logic [31:0]   fv [8];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 0;

    always #2 clk = ~clk;

    brfold_iq u_brfold_iq (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_cnt(fetch_cnt), .fetch_pc(fetch_pc),
        .fetch_words(fetch_words), .fetch_free(fetch_free),
        .cr_value(cr_value), .cr_valid(cr_valid),
        .disp_valid(disp_valid), .disp_words(disp_words), .disp_pc(disp_pc),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    function automatic logic [31:0] nop(input int k);
        return {6'h01, 26'(k)};
    endfunction
    function automatic logic [31:0] jmp(input int d);
        return {6'h12, 24'(d), 2'b00};
    endfunction
    function automatic logic [31:0] bc(input logic s, input int b, input int d);
        return {6'h10, s, 4'b0000, 5'(b), 14'(d), 2'b00};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fetch_cycle(input int n, input logic [31:0] pc);
        fetch_valid = 1'b1;
        fetch_cnt   = 4'(n);
        fetch_pc    = pc;
        for (int f = 0; f < 8; f++) fetch_words[f*32 +: 32] = fv[f];
        step();
        fetch_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; fetch_valid = 1'b0; fetch_cnt = '0; fetch_pc = '0;
        fetch_words = '0; cr_value = '0; cr_valid = '0;
        for (int f = 0; f < 8; f++) fv[f] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", "disp_valid", 64'(disp_valid), 64'h0);
        chk("R1", "redirect_valid", 64'(redirect_valid), 64'h0);
        chk("R1", "fetch_free", 64'(fetch_free), 64'd8);
    endtask

    task automatic t_dispatch_order();
        do_reset();
        for (int f = 0; f < 5; f++) fv[f] = nop(f + 1);
        fetch_cycle(5, 32'h100);
        chk("R3", "disp_valid", 64'(disp_valid), 64'b111);
        chk("R2", "lane0 pc", 64'(disp_pc[31:0]), 64'h100);
        chk("R2", "lane2 pc", 64'(disp_pc[95:64]), 64'h108);
        chk("R3", "lane1 word", 64'(disp_words[63:32]), 64'(nop(2)));
        chk("R11", "free", 64'(fetch_free), 64'd3);
        step();
        chk("R3", "disp_valid tail", 64'(disp_valid), 64'b011);
        chk("R3", "tail lane1 pc", 64'(disp_pc[63:32]), 64'h110);
        chk("R11", "free tail", 64'(fetch_free), 64'd6);
        step();
        chk("R11", "free empty", 64'(fetch_free), 64'd8);
    endtask

    task automatic t_pending_and_overflow();
        do_reset();
        fv[0] = nop(10); fv[1] = bc(1'b1, 5, 4);
        for (int f = 2; f < 8; f++) fv[f] = nop(10 + f);
        fetch_cycle(8, 32'h200);
        chk("R4", "disp before pending", 64'(disp_valid), 64'b001);
        chk("R4", "no redirect pending", 64'(redirect_valid), 64'h0);
        chk("R11", "free full", 64'(fetch_free), 64'd0);
        step();
        chk("R4", "pending blocks", 64'(disp_valid), 64'b000);
        chk("R11", "free one", 64'(fetch_free), 64'd1);
        fv[0] = nop(40); fv[1] = nop(41); fv[2] = nop(42);
        fetch_cycle(3, 32'h300);
        chk("R2", "free after excess", 64'(fetch_free), 64'd0);
        chk("R4", "still blocked", 64'(disp_valid), 64'b000);
        cr_valid[5] = 1'b1; cr_value[5] = 1'b0;
        #1;
        chk("R7", "not-taken no redirect", 64'(redirect_valid), 64'h0);
        step();
        chk("R7", "after delete disp", 64'(disp_valid), 64'b111);
        chk("R7", "after delete lane0 pc", 64'(disp_pc[31:0]), 64'h208);
        chk("R11", "free after delete", 64'(fetch_free), 64'd1);
        step();
        chk("R7", "order lane2 pc", 64'(disp_pc[95:64]), 64'h21C);
        step();
        chk("R2", "only one extra", 64'(disp_valid), 64'b001);
        chk("R2", "extra pc", 64'(disp_pc[31:0]), 64'h300);
        chk("R2", "extra word", 64'(disp_words[31:0]), 64'(nop(40)));
        step();
        chk("R2", "drained", 64'(fetch_free), 64'd8);
    endtask

    task automatic t_fold_dispatch_collide();
        do_reset();
        fv[0] = nop(1); fv[1] = nop(2); fv[2] = jmp(16); fv[3] = nop(3);
        fetch_cycle(4, 32'h400);
        chk("R5", "older dispatched", 64'(disp_valid), 64'b011);
        chk("R5", "lane1 pc", 64'(disp_pc[63:32]), 64'h404);
        chk("R5", "redirect", 64'(redirect_valid), 64'h1);
        chk("R5", "redirect pc", 64'(redirect_pc), 64'h448);
        fv[0] = nop(7); fv[1] = nop(8);
        fetch_cycle(2, 32'h40C);
        chk("R10", "stale fetch dropped", 64'(fetch_free), 64'd8);
        chk("R5", "younger flushed", 64'(disp_valid), 64'b000);
        chk("R5", "redirect gone", 64'(redirect_valid), 64'h0);
    endtask

    task automatic t_taken_cond();
        do_reset();
        cr_valid[3] = 1'b1; cr_value[3] = 1'b1;
        fv[0] = bc(1'b1, 3, -4); fv[1] = nop(5);
        fetch_cycle(2, 32'h500);
        chk("R6", "redirect", 64'(redirect_valid), 64'h1);
        chk("R6", "backward target", 64'(redirect_pc), 64'h4F0);
        chk("R4", "branch not dispatched", 64'(disp_valid), 64'b000);
        step();
        chk("R6", "flushed", 64'(fetch_free), 64'd8);
    endtask

    task automatic t_window_limit();
        do_reset();
        for (int f = 0; f < 5; f++) fv[f] = nop(20 + f);
        fv[5] = jmp(8);
        fetch_cycle(6, 32'h600);
        chk("R8", "slot5 not scanned", 64'(redirect_valid), 64'h0);
        chk("R8", "front dispatched", 64'(disp_valid), 64'b111);
        step();
        chk("R8", "in window redirect", 64'(redirect_valid), 64'h1);
        chk("R8", "target", 64'(redirect_pc), 64'h634);
        chk("R8", "older pair", 64'(disp_valid), 64'b011);
        step();
        chk("R8", "empty", 64'(fetch_free), 64'd8);
    endtask

    task automatic t_one_fold();
        do_reset();
        fv[0] = jmp(32'h40); fv[1] = jmp(4);
        fetch_cycle(2, 32'h700);
        chk("R9", "oldest target", 64'(redirect_pc), 64'h800);
        step();
        chk("R9", "second flushed", 64'(fetch_free), 64'd8);
        chk("R9", "no second redirect", 64'(redirect_valid), 64'h0);
        cr_valid[2] = 1'b1; cr_value[2] = 1'b0;
        fv[0] = bc(1'b1, 2, 8); fv[1] = jmp(8);
        fetch_cycle(2, 32'h780);
        chk("R9", "jump waits", 64'(redirect_valid), 64'h0);
        step();
        chk("R9", "jump next cycle", 64'(redirect_valid), 64'h1);
        chk("R9", "jump target", 64'(redirect_pc), 64'h7A4);
        chk("R7", "one left", 64'(fetch_free), 64'd7);
        step();
        chk("R9", "empty", 64'(fetch_free), 64'd8);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_dispatch_order();
        t_pending_and_overflow();
        t_fold_dispatch_collide();
        t_taken_cond();
        t_window_limit();
        t_one_fold();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule